// File: doc/BRIEF.md
# Configurable Single-Precision Floating-Point Multiplier

This block multiplies two IEEE-754 binary32 values and returns a binary32 result together with three condition flags. The second operand is chosen from four sources: a register value, a constant, a 20-bit immediate that fills the upper bits of the word, or a full 32-bit immediate. Per operation, the caller selects how subnormal values are treated, a power-of-two pre-scale of the first operand, the rounding direction, and an optional clamp of the result to the unit interval.

The pre-scale is exact and has an unbounded exponent range. Only the final rounded product can overflow or underflow. A dedicated subnormal mode forces the product to +0.0 whenever a flushed operand is zero, and this holds even against infinity or NaN. The datapath is combinational and ends in a single output register. When `OUT_REG` is 0, that register is left out.

Top module: `fmul_unit`

## Requirements
- R1: With `OUT_REG`=1, `out_valid` equals `in_valid` one clock edge later. Result and flags belong to the operation applied on that edge. Normal operands produce the correctly rounded product.
- R2: `rnd_mode` selects the rounding direction: 0 = nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero.
- R3: `dn_mode` 0 keeps subnormal inputs and outputs, and code 3 acts exactly like 0. `dn_mode` 1 replaces subnormal inputs with zero and subnormal results with zero, keeping the sign in both cases.
- R4: `dn_mode` 2 flushes like mode 1. In addition, if either operand is zero after flushing, the result is +0.0 (0x00000000), whatever the signs and even if the other operand is infinity or NaN.
- R5: `scale_sel` code k (0 to 6) multiplies the first operand by 2^(k-3). Code 3 and code 7 pass the operand through unchanged.
- R6: The pre-scale never overflows or underflows by itself. Only the rounded final product can do so.
- R7: Every NaN result is 0x7FFFFFFF. Infinity times zero gives that NaN when `dn_mode` is not 2. Any other product involving an infinity is an infinity whose sign is the XOR of the operand signs.
- R8: On overflow the result is infinity or the largest finite magnitude (exponent 0xFE, fraction all ones). Nearest-even gives infinity and toward-zero gives the largest finite value. Toward plus infinity gives infinity only for positive results, and toward minus infinity gives infinity only for negative results.
- R9: With `dn_mode` 0, products below the normal range produce correctly rounded subnormal results, including rounding up to the smallest subnormal 0x00000001.
- R10: With `sat_en` set, the result is limited to [+0.0, 1.0]. NaN and any negative value, including -0.0, become 0x00000000. Values above 1.0, including +infinity, become 0x3F800000.
- R11: `src_sel` picks the second operand: 0 = `b_reg`, 1 = `b_const`, 2 = {`b_imm20`, 12 zero bits}, 3 = `b_imm32`. In source 3, `rnd_mode` and `scale_sel` are ignored, and the operation rounds to nearest-even with no scale.
- R12: The flags describe the final (post-clamp) result. `cc_zero` is set when bits 30:0 are zero, `cc_neg` is bit 31, and `cc_nan` is set when the exponent field is all ones and the fraction is non-zero.
- R13: While `rst_n` is low, `out_valid`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation applied this cycle |
| op_a | input | 32 | First operand (pre-scaled) |
| b_reg | input | 32 | Second operand, register source |
| b_const | input | 32 | Second operand, constant source |
| b_imm20 | input | 20 | Upper 20 bits of an immediate second operand |
| b_imm32 | input | 32 | Full immediate second operand |
| src_sel | input | 2 | Second operand source select |
| dn_mode | input | 2 | Subnormal handling mode |
| scale_sel | input | 3 | Pre-scale code for the first operand |
| rnd_mode | input | 2 | Rounding direction |
| sat_en | input | 1 | Clamp result to [0, 1] |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Product |
| cc_zero | output | 1 | Result is a zero |
| cc_neg | output | 1 | Result sign bit |
| cc_nan | output | 1 | Result is NaN |

## Verification
Every result and flag is due exactly one rising edge after the cycle in which `in_valid` and the operands are presented. The datapath is combinational into one register, so nothing arrives earlier or later. The bench changes inputs on the falling edge and reads `result`, the flags and `out_valid` 1 ns after the next rising edge, which is the first point where the new value is present. Each scenario task applies one operation per cycle back to back. Its expected words are hand-derived bit patterns, independent of the datapath.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int FP_W     = 32;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = FP_W - EXP_W - 1;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int PROD_W   = 2 * SIG_W;
  localparam int XEXP_W   = 12;
  localparam int IMM_W    = 20;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;
  localparam int LSB_OFF  = BIAS + FRAC_W;
  localparam int EMIN_LSB = 1 - LSB_OFF;
  localparam logic [FP_W-1:0] QNAN_W = {1'b0, {(FP_W-1){1'b1}}};
  localparam logic [FP_W-1:0] ONE_W  = {2'b00, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};

  typedef enum logic [1:0] {DN_KEEP = 2'd0, DN_FLUSH = 2'd1, DN_FORCEZ = 2'd2, DN_RSVD = 2'd3} dn_mode_e;
  typedef enum logic [1:0] {RM_NEAR = 2'd0, RM_DOWN = 2'd1, RM_UP = 2'd2, RM_TRUNC = 2'd3} rnd_e;
  typedef enum logic [1:0] {SRC_REG = 2'd0, SRC_CONST = 2'd1, SRC_IMM20 = 2'd2, SRC_IMM32 = 2'd3} src_e;

  typedef struct packed {
    logic                     nan;
    logic                     inf;
    logic                     zero;
    logic signed [XEXP_W-1:0] exp;   // weight of significand LSB
    logic [SIG_W-1:0]         sig;
  } fp_unpk_t;

  function automatic fp_unpk_t fp_unpack(input logic [FP_W-1:0] w, input logic flush);
    fp_unpk_t u;
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = w[FP_W-2:FRAC_W];
    f = w[FRAC_W-1:0];
    u.nan  = (e == '1) && (f != '0);
    u.inf  = (e == '1) && (f == '0);
    u.zero = 1'b0;
    if (e == '0) begin
      u.zero = flush || (f == '0);
      u.sig  = u.zero ? '0 : {1'b0, f};
      u.exp  = XEXP_W'(EMIN_LSB);
    end else begin
      u.sig  = {1'b1, f};
      u.exp  = XEXP_W'(int'(e) - LSB_OFF);
    end
    return u;
  endfunction

  function automatic logic [5:0] fp_lead_one(input logic [PROD_W-1:0] p);
    logic [5:0] pos;
    pos = '0;
    for (int i = 0; i < PROD_W; i++) if (p[i]) pos = 6'(i);
    return pos;
  endfunction

  function automatic logic fp_round_up(input rnd_e rm, input logic sgn, input logic lsb,
                                       input logic g, input logic s);
    case (rm)
      RM_NEAR: return g & (s | lsb);
      RM_DOWN: return sgn & (g | s);
      RM_UP:   return ~sgn & (g | s);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [FP_W-1:0] fp_ovf_word(input rnd_e rm, input logic sgn);
    logic to_inf;
    case (rm)
      RM_NEAR: to_inf = 1'b1;
      RM_DOWN: to_inf = sgn;
      RM_UP:   to_inf = ~sgn;
      default: to_inf = 1'b0;
    endcase
    return to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                  : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  endfunction
endpackage

// File: rtl/fmul_src_mux.sv
module fmul_src_mux
  import fmul_pkg::*;
(
  input  logic [FP_W-1:0]  b_reg,
  input  logic [FP_W-1:0]  b_const,
  input  logic [IMM_W-1:0] b_imm20,
  input  logic [FP_W-1:0]  b_imm32,
  input  logic [1:0]       src_sel,
  input  logic [2:0]       scale_sel,
  input  logic [1:0]       rnd_mode,
  output logic [FP_W-1:0]  b_word,
  output logic signed [3:0] scale_n,
  output logic [1:0]       rnd_eff
);
  localparam int SCALE_MID = 3;
  logic full_imm;

  assign full_imm = src_e'(src_sel) == SRC_IMM32;

  always_comb begin
    case (src_e'(src_sel))
      SRC_REG:   b_word = b_reg;
      SRC_CONST: b_word = b_const;
      SRC_IMM20: b_word = {b_imm20, {(FP_W-IMM_W){1'b0}}};
      default:   b_word = b_imm32;
    endcase
  end

  // 32-bit immediate form: fixed nearest-even, no pre-scale
  assign rnd_eff = full_imm ? RM_NEAR : rnd_mode;
  assign scale_n = (full_imm || scale_sel == 3'd7) ? 4'sd0
                                                   : 4'(int'(scale_sel) - SCALE_MID);
endmodule

// File: rtl/fmul_core.sv
module fmul_core
  import fmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FP_W-1:0]   a_word,
  input  logic [FP_W-1:0]   b_word,
  input  logic [1:0]        dn_mode,
  input  logic signed [3:0] scale_n,
  input  logic [1:0]        rnd_mode,
  output logic [FP_W-1:0]   raw_word
);
  localparam int EXT_W  = PROD_W + 4;
  localparam int SH_CAP = PROD_W + 2;

  fp_unpk_t ua, ub;
  rnd_e rm;
  logic flush_en, forcez_en, sgn;
  logic force_zero, special_nan, special_inf, special_zero;
  logic ovf_hit, denorm_out, denorm_flushed;
  logic [PROD_W-1:0] prod;
  logic [5:0] lead, sh6;
  logic [EXT_W-1:0] ext, mask;
  logic [SIG_W:0] m_pre, m_rnd;
  logic guard_b, sticky_b, inc;
  int e_sum, sh, lsb_exp, exp_f;

  assign rm        = rnd_e'(rnd_mode);
  assign flush_en  = dn_mode_e'(dn_mode) == DN_FLUSH || dn_mode_e'(dn_mode) == DN_FORCEZ;
  assign forcez_en = dn_mode_e'(dn_mode) == DN_FORCEZ;
  assign ua        = fp_unpack(a_word, flush_en);
  assign ub        = fp_unpack(b_word, flush_en);
  assign sgn       = a_word[FP_W-1] ^ b_word[FP_W-1];

  assign force_zero   = forcez_en & (ua.zero | ub.zero);
  assign special_nan  = ua.nan | ub.nan | (ua.inf & ub.zero) | (ub.inf & ua.zero);
  assign special_inf  = ua.inf | ub.inf;
  assign special_zero = ua.zero | ub.zero;

  assign prod = ua.sig * ub.sig;
  assign lead = fp_lead_one(prod);

  // Significand alignment and rounding; exponent kept wide so scale never saturates
  always_comb begin
    e_sum = int'(ua.exp) + int'(ub.exp) + int'(scale_n);
    sh    = int'(lead) - FRAC_W;
    if (EMIN_LSB - e_sum > sh) sh = EMIN_LSB - e_sum;
    ext      = {2'b00, prod, 2'b00};
    guard_b  = 1'b0;
    sticky_b = 1'b0;
    mask     = '0;
    if (sh >= 0) begin
      sh6      = (sh > SH_CAP) ? 6'(SH_CAP) : 6'(sh);
      mask     = (EXT_W'(1) << (sh6 + 6'd1)) - EXT_W'(1);
      m_pre    = (SIG_W+1)'(ext >> (sh6 + 6'd2));
      guard_b  = ext[sh6 + 6'd1];
      sticky_b = |(ext & mask);
    end else begin
      sh6   = 6'(-sh);
      m_pre = (SIG_W+1)'(prod << sh6);
    end
    inc     = fp_round_up(rm, sgn, m_pre[0], guard_b, sticky_b);
    m_rnd   = m_pre + {{SIG_W{1'b0}}, inc};
    lsb_exp = e_sum + sh;
    if (m_rnd[SIG_W]) begin
      m_rnd   = m_rnd >> 1;
      lsb_exp = lsb_exp + 1;
    end
    exp_f = lsb_exp + LSB_OFF;
  end

  always_comb begin
    ovf_hit        = 1'b0;
    denorm_out     = 1'b0;
    denorm_flushed = 1'b0;
    if (force_zero)        raw_word = '0;
    else if (special_nan)  raw_word = QNAN_W;
    else if (special_inf)  raw_word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (special_zero) raw_word = {sgn, {(FP_W-1){1'b0}}};
    else if (!m_rnd[SIG_W-1]) begin
      denorm_out = m_rnd != '0;
      if (flush_en) begin
        raw_word       = {sgn, {(FP_W-1){1'b0}}};
        denorm_flushed = denorm_out;
      end else begin
        raw_word = {sgn, {EXP_W{1'b0}}, m_rnd[FRAC_W-1:0]};
      end
    end else if (exp_f >= EXP_ALL1) begin
      ovf_hit  = 1'b1;
      raw_word = fp_ovf_word(rm, sgn);
    end else begin
      raw_word = {sgn, EXP_W'(exp_f), m_rnd[FRAC_W-1:0]};
    end
  end

  p_forcez_plus_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (forcez_en && (a_word[FP_W-2:FRAC_W] == '0 || b_word[FP_W-2:FRAC_W] == '0)) |-> raw_word == '0);

  p_nan_canonical_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_word[FP_W-2:FRAC_W] == '1 && raw_word[FRAC_W-1:0] != '0) |-> raw_word == QNAN_W);

  p_flush_no_subnormal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |-> !(raw_word[FP_W-2:FRAC_W] == '0 && raw_word[FRAC_W-1:0] != '0));

  p_trunc_overflow_finite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && rm == RM_TRUNC) |-> raw_word[FP_W-2:FRAC_W] != '1);

  p_flushed_is_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    denorm_flushed |-> raw_word[FP_W-2:0] == '0);
endmodule

// File: rtl/fmul_post.sv
module fmul_post
  import fmul_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FP_W-1:0] raw_word,
  input  logic            sat_en,
  output logic [FP_W-1:0] fin_word,
  output logic            fin_zero,
  output logic            fin_neg,
  output logic            fin_nan
);
  logic raw_is_nan;

  assign raw_is_nan = raw_word[FP_W-2:FRAC_W] == '1 && raw_word[FRAC_W-1:0] != '0;

  always_comb begin
    fin_word = raw_word;
    if (sat_en) begin
      if (raw_is_nan || raw_word[FP_W-1]) fin_word = '0;
      else if (raw_word > ONE_W)          fin_word = ONE_W;
    end
  end

  assign fin_zero = fin_word[FP_W-2:0] == '0;
  assign fin_neg  = fin_word[FP_W-1];
  assign fin_nan  = fin_word[FP_W-2:FRAC_W] == '1 && fin_word[FRAC_W-1:0] != '0;

  p_sat_in_unit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_en |-> (!fin_word[FP_W-1] && fin_word <= ONE_W));

  p_sat_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sat_en |-> (!fin_nan && !fin_neg));
endmodule

// File: rtl/fmul_unit.sv
module fmul_unit
  import fmul_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] b_reg,
  input  logic [31:0] b_const,
  input  logic [19:0] b_imm20,
  input  logic [31:0] b_imm32,
  input  logic [1:0]  src_sel,
  input  logic [1:0]  dn_mode,
  input  logic [2:0]  scale_sel,
  input  logic [1:0]  rnd_mode,
  input  logic        sat_en,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        cc_zero,
  output logic        cc_neg,
  output logic        cc_nan
);
  logic [FP_W-1:0]   b_word, raw_word, fin_word;
  logic signed [3:0] scale_n;
  logic [1:0]        rnd_eff;
  logic              fin_zero, fin_neg, fin_nan;

  fmul_src_mux u_src (
    .b_reg(b_reg), .b_const(b_const), .b_imm20(b_imm20), .b_imm32(b_imm32),
    .src_sel(src_sel), .scale_sel(scale_sel), .rnd_mode(rnd_mode),
    .b_word(b_word), .scale_n(scale_n), .rnd_eff(rnd_eff)
  );

  fmul_core u_core (
    .clk(clk), .rst_n(rst_n), .a_word(op_a), .b_word(b_word), .dn_mode(dn_mode),
    .scale_n(scale_n), .rnd_mode(rnd_eff), .raw_word(raw_word)
  );

  fmul_post u_post (
    .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .sat_en(sat_en),
    .fin_word(fin_word), .fin_zero(fin_zero), .fin_neg(fin_neg), .fin_nan(fin_nan)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
          cc_zero   <= 1'b0;
          cc_neg    <= 1'b0;
          cc_nan    <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result  <= fin_word;
            cc_zero <= fin_zero;
            cc_neg  <= fin_neg;
            cc_nan  <= fin_nan;
          end
        end
      end

      p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

      p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result == $past(fin_word));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = fin_word;
      assign cc_zero   = fin_zero;
      assign cc_neg    = fin_neg;
      assign cc_nan    = fin_nan;
    end
  endgenerate
endmodule

// File: tb/fmul_unit_tb.sv
module fmul_unit_tb_top;
  localparam logic [1:0] NE = 2'd0, DN = 2'd1, UP = 2'd2, TZ = 2'd3;
  localparam logic [2:0] PASS = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sat_en = 1'b0;
  logic [31:0] op_a = '0, b_reg = '0, b_const = '0, b_imm32 = '0;
  logic [19:0] b_imm20 = '0;
  logic [1:0] src_sel = '0, dn_mode = '0, rnd_mode = '0;
  logic [2:0] scale_sel = PASS;
  logic out_valid, cc_zero, cc_neg, cc_nan;
  logic [31:0] result;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fmul_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .b_reg(b_reg),
    .b_const(b_const), .b_imm20(b_imm20), .b_imm32(b_imm32), .src_sel(src_sel),
    .dn_mode(dn_mode), .scale_sel(scale_sel), .rnd_mode(rnd_mode), .sat_en(sat_en),
    .out_valid(out_valid), .result(result), .cc_zero(cc_zero), .cc_neg(cc_neg), .cc_nan(cc_nan)
  );

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one operation; result and flags due one edge later
  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] dn, input logic [2:0] sc, input logic [1:0] rm,
                     input logic sat, input logic [1:0] src, input logic [31:0] expv);
    logic [3:0] fl;
    @(negedge clk);
    in_valid  = 1'b1;
    op_a      = a;
    dn_mode   = dn;
    scale_sel = sc;
    rnd_mode  = rm;
    sat_en    = sat;
    src_sel   = src;
    b_reg     = (src == 2'd0) ? b : 32'hDEAD_BEEF;
    b_const   = (src == 2'd1) ? b : 32'h4120_0000;
    b_imm20   = (src == 2'd2) ? b[31:12] : 20'hC0A00;
    b_imm32   = (src == 2'd3) ? b : 32'h3E00_0000;
    @(posedge clk);
    #1;
    fl = {1'b1, expv[30:0] == 31'd0, expv[31], expv[30:23] == 8'hFF && expv[22:0] != 23'd0};
    check(req, {out_valid, cc_zero, cc_neg, cc_nan, result}, {fl, expv});
  endtask

  task automatic t_reset();   // R13
    #1;
    check("R13 reset", {out_valid, cc_zero, cc_neg, cc_nan, result}, 36'd0);
  endtask

  task automatic t_basic();   // R1
    run("R1 1.5*2", 32'h3FC0_0000, 32'h4000_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h4040_0000);
    run("R1 -2.5*4", 32'hC020_0000, 32'h4080_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'hC120_0000);
  endtask

  task automatic t_round();   // R2
    run("R2 near", 32'h3F80_0001, 32'h3F80_0001, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h3F80_0002);
    run("R2 up", 32'h3F80_0001, 32'h3F80_0001, 2'd0, PASS, UP, 1'b0, 2'd0, 32'h3F80_0003);
    run("R2 trunc", 32'h3F80_0001, 32'h3F80_0001, 2'd0, PASS, TZ, 1'b0, 2'd0, 32'h3F80_0002);
    run("R2 down neg", 32'hBF80_0001, 32'h3F80_0001, 2'd0, PASS, DN, 1'b0, 2'd0, 32'hBF80_0003);
    run("R2 up neg", 32'hBF80_0001, 32'h3F80_0001, 2'd0, PASS, UP, 1'b0, 2'd0, 32'hBF80_0002);
    run("R2 tie even", 32'h3F80_0001, 32'h3FC0_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h3FC0_0002);
    run("R2 tie trunc", 32'h3F80_0001, 32'h3FC0_0000, 2'd0, PASS, TZ, 1'b0, 2'd0, 32'h3FC0_0001);
  endtask

  task automatic t_scale();   // R5 R6
    run("R5 x8", 32'h4040_0000, 32'h3F80_0000, 2'd0, 3'd6, NE, 1'b0, 2'd0, 32'h41C0_0000);
    run("R5 /8", 32'h4040_0000, 32'h3F80_0000, 2'd0, 3'd0, NE, 1'b0, 2'd0, 32'h3EC0_0000);
    run("R5 /2", 32'h4040_0000, 32'h3F80_0000, 2'd0, 3'd2, NE, 1'b0, 2'd0, 32'h3FC0_0000);
    run("R5 code7", 32'h4040_0000, 32'h3F80_0000, 2'd0, 3'd7, NE, 1'b0, 2'd0, 32'h4040_0000);
    run("R6 high", 32'h7F00_0000, 32'h3C00_0000, 2'd0, 3'd6, NE, 1'b0, 2'd0, 32'h7D00_0000);
    run("R6 low", 32'h0000_0001, 32'h4180_0000, 2'd0, 3'd0, NE, 1'b0, 2'd0, 32'h0000_0002);
  endtask

  task automatic t_subnormal();   // R3 R4 R9
    run("R3 keep", 32'h0040_0000, 32'h4000_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h0080_0000);
    run("R3 code3", 32'h0040_0000, 32'h4000_0000, 2'd3, PASS, NE, 1'b0, 2'd0, 32'h0080_0000);
    run("R3 flush in", 32'h8040_0000, 32'h4000_0000, 2'd1, PASS, NE, 1'b0, 2'd0, 32'h8000_0000);
    run("R9 sub out", 32'h0080_0000, 32'h3F00_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h0040_0000);
    run("R3 flush out", 32'h0080_0000, 32'h3F00_0000, 2'd1, PASS, NE, 1'b0, 2'd0, 32'h0000_0000);
    run("R9 tie to 0", 32'h0000_0001, 32'h3F00_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h0000_0000);
    run("R9 up to min", 32'h0000_0001, 32'h3F00_0000, 2'd0, PASS, UP, 1'b0, 2'd0, 32'h0000_0001);
    run("R3 flush neg", 32'h8000_0001, 32'h4040_0000, 2'd1, PASS, NE, 1'b0, 2'd0, 32'h8000_0000);
    run("R4 sub zero", 32'h8000_0001, 32'h4040_0000, 2'd2, PASS, NE, 1'b0, 2'd0, 32'h0000_0000);
    run("R4 inf*0", 32'h7F80_0000, 32'h0000_0000, 2'd2, PASS, NE, 1'b0, 2'd0, 32'h0000_0000);
    run("R4 nan*-0", 32'h7FC0_0000, 32'h8000_0000, 2'd2, PASS, NE, 1'b0, 2'd0, 32'h0000_0000);
  endtask

  task automatic t_special();   // R7 R8 R12
    run("R7 inf*0", 32'h7F80_0000, 32'h0000_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h7FFF_FFFF);
    run("R7 nan", 32'h7FC0_0000, 32'h3F80_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h7FFF_FFFF);
    run("R7 inf*-2", 32'h7F80_0000, 32'hC000_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'hFF80_0000);
    run("R8 near", 32'h7F00_0000, 32'h4080_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h7F80_0000);
    run("R8 trunc", 32'h7F00_0000, 32'h4080_0000, 2'd0, PASS, TZ, 1'b0, 2'd0, 32'h7F7F_FFFF);
    run("R8 up neg", 32'hFF00_0000, 32'h4080_0000, 2'd0, PASS, UP, 1'b0, 2'd0, 32'hFF7F_FFFF);
    run("R8 down neg", 32'hFF00_0000, 32'h4080_0000, 2'd0, PASS, DN, 1'b0, 2'd0, 32'hFF80_0000);
    run("R12 neg zero", 32'h8000_0000, 32'h3F80_0000, 2'd0, PASS, NE, 1'b0, 2'd0, 32'h8000_0000);
  endtask

  task automatic t_sat();   // R10 R12
    run("R10 >1", 32'h4040_0000, 32'h3F80_0000, 2'd0, PASS, NE, 1'b1, 2'd0, 32'h3F80_0000);
    run("R10 neg", 32'hC000_0000, 32'h3F80_0000, 2'd0, PASS, NE, 1'b1, 2'd0, 32'h0000_0000);
    run("R10 inside", 32'h3F00_0000, 32'h3F00_0000, 2'd0, PASS, NE, 1'b1, 2'd0, 32'h3E80_0000);
    run("R10 nan", 32'h7FC0_0000, 32'h3F80_0000, 2'd0, PASS, NE, 1'b1, 2'd0, 32'h0000_0000);
    run("R10 inf", 32'h7F80_0000, 32'h4000_0000, 2'd0, PASS, NE, 1'b1, 2'd0, 32'h3F80_0000);
    run("R12 sat -0", 32'h8000_0000, 32'h3F80_0000, 2'd0, PASS, NE, 1'b1, 2'd0, 32'h0000_0000);
  endtask

  task automatic t_source();   // R11
    run("R11 const", 32'h3FC0_0000, 32'h4080_0000, 2'd0, PASS, NE, 1'b0, 2'd1, 32'h40C0_0000);
    run("R11 imm20", 32'h3FC0_0000, 32'h4000_0000, 2'd0, PASS, NE, 1'b0, 2'd2, 32'h4040_0000);
    run("R11 imm32 fixed", 32'h3F80_0001, 32'h3F80_0001, 2'd0, 3'd6, UP, 1'b0, 2'd3, 32'h3F80_0002);
  endtask

  task automatic t_idle();   // R1: valid drops one edge after in_valid does
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: got %b expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_basic();
    t_round();
    t_scale();
    t_subnormal();
    t_special();
    t_sat();
    t_source();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule